// File: doc/BRIEF.md
# Read-Enable Alignment Delay with Depth Training

A DDR memory returns read data with no valid strobe of its own. Something on the chip must therefore work out which fast-clock cycle holds the first word of each burst. This block does that for one data byte. The controller's read-enable pulse is one fast cycle long for a 4-beat burst and two cycles long for an 8-beat burst. The pulse enters a shift line clocked by the fast clock. A tap on that line is chosen at run time, and a few fixed flip-flops follow the tap. The last flip-flop drives the write enable of the capture FIFO for that byte. The tap depth absorbs the round-trip delay that CAS latency, additive latency and board flight time add.

The depth is found by training. The controller writes a known word to memory and then reads it back many times. After a start strobe, the block tries depth 0 first. On each training read it looks at the captured word in the first cycle that its delayed enable goes high. If that word equals the expected training word, the depth is locked and a done flag rises. If not, the block moves to the next depth and waits for the next training read. A training read is accepted only when the delay pipeline is empty, so a pulse from an earlier read cannot corrupt a trial. If every depth up to the last one fails, a not-found flag rises instead. Each byte lane has its own instance and trains on its own.

Top module: `rdq_align`

## Requirements
- R1: While reset is held and just after it is released, `fifo_we_o`, `cal_done_o` and `cal_fail_o` are 0 and `depth_o` is 0.
- R2: Count the first rising edge that samples `rd_pulse_i` high as edge 1. `fifo_we_o` then goes high right after edge `depth_o + OUT_STAGES + 1`.
- R3: `fifo_we_o` stays high for exactly as many cycles as `rd_pulse_i` was high: 1 cycle for a 4-beat burst and 2 cycles for an 8-beat burst.
- R4: After `cal_start_i`, trials begin at depth 0. Each training read tests one depth. The block compares `cap_word_i` with `train_word_i` in the first cycle in which the delayed enable is high. On a mismatch the depth goes up by exactly one. The first matching depth is locked, so locking depth d takes d+1 training reads.
- R5: Once a depth is locked, `cal_done_o` is 1 and `depth_o` holds the locked value. Later reads with non-matching captured words change neither of them.
- R6: If the trial at depth MAX_DEPTH-1 (15) mismatches, `cal_fail_o` goes to 1 and stays there. `cal_done_o` stays 0 and `depth_o` stays at 15. `cal_done_o` and `cal_fail_o` are never high together.
- R7: The first edge after a `cal_start_i` pulse clears `cal_done_o` and `cal_fail_o` and sets `depth_o` to 0, whatever state the block was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_pulse_i | input | 1 | Controller read-enable pulse |
| cal_start_i | input | 1 | One-cycle strobe that starts depth training |
| cap_word_i | input | WORD_W | Parallel word from the byte's deserializer |
| train_word_i | input | WORD_W | Expected first training word |
| fifo_we_o | output | 1 | Write enable for the read-data capture FIFO |
| depth_o | output | DEPTH_W | Current or locked tap depth |
| cal_done_o | output | 1 | Depth locked |
| cal_fail_o | output | 1 | No depth matched |

## Verification
The bench sweeps the true round-trip latency across every reachable depth, with 4-beat and 8-beat pulses in turn. For each case it checks the locked depth and the number of training reads used. An off-by-one in the tap index or in the comparison cycle would lock one depth away from the right one, or take one read too many. It then checks the enable cycle by cycle in normal reads. A miscounted output stage would shift the enable, and a broken pulse path would shorten or stretch it. Latencies just below and just above the reachable range must give the not-found flag with the depth parked at 15. A design that wrapped the depth counter would keep searching instead of failing. A restart after failure must clear every flag.

// File: rtl/rdq_align_pkg.sv
package rdq_align_pkg;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_ARM,
    CAL_WAIT,
    CAL_LOCK,
    CAL_FAIL
  } cal_state_t;

  // Edge index (edge 1 samples the pulse) after which the enable is high.
  function automatic int unsigned en_rise_edge(int unsigned depth, int unsigned stages);
    return depth + stages + 1;
  endfunction

  // True when the given depth is the last one the line offers.
  function automatic logic is_last_depth(int unsigned depth, int unsigned max_depth);
    return depth == max_depth - 1;
  endfunction

endpackage

// File: rtl/rdq_tapline.sv
module rdq_tapline #(
  parameter int MAX_DEPTH  = 16,
  parameter int OUT_STAGES = 2,
  parameter int DEPTH_W    = $clog2(MAX_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               en_o,
  output logic               en_rise_o,
  output logic               empty_o
);

  logic [MAX_DEPTH-1:0]  line_q;
  logic [OUT_STAGES-1:0] stage_q;
  logic                  tap_w;
  logic                  en_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= {line_q[MAX_DEPTH-2:0], pulse_i};
  end

  assign tap_w = line_q[depth_i];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= tap_w;
  end

  for (genvar s = 1; s < OUT_STAGES; s++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= 1'b0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_prev_q <= 1'b0;
    else        en_prev_q <= en_o;
  end

  assign en_o      = stage_q[OUT_STAGES-1];
  assign en_rise_o = en_o & ~en_prev_q;
  assign empty_o   = ~(|line_q) & ~(|stage_q);

  // R3: an enable can only start if something was in flight the cycle before
  a_r3_rise_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise_o |-> !$past(empty_o));

endmodule

// File: rtl/rdq_cal_fsm.sv
module rdq_cal_fsm
  import rdq_align_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_DEPTH = 16,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal_start_i,
  input  logic               pulse_i,
  input  logic               pipe_empty_i,
  input  logic               en_rise_i,
  input  logic [WORD_W-1:0]  cap_word_i,
  input  logic [WORD_W-1:0]  train_word_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               done_o,
  output logic               fail_o
);

  cal_state_t         state_q;
  logic [DEPTH_W-1:0] depth_q;
  logic               pulse_prev_q;
  logic               pulse_rise_w;
  logic               word_match_w;
  logic               at_last_w;

  assign pulse_rise_w = pulse_i & ~pulse_prev_q;
  assign word_match_w = (cap_word_i == train_word_i);
  assign at_last_w    = is_last_depth(int'(depth_q), MAX_DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_prev_q <= 1'b0;
    else        pulse_prev_q <= pulse_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      depth_q <= '0;
    end else if (cal_start_i) begin
      state_q <= CAL_ARM;
      depth_q <= '0;
    end else begin
      unique case (state_q)
        CAL_ARM:  if (pipe_empty_i && pulse_rise_w) state_q <= CAL_WAIT;
        CAL_WAIT: if (en_rise_i) begin
          if (word_match_w)   state_q <= CAL_LOCK;
          else if (at_last_w) state_q <= CAL_FAIL;
          else begin
            depth_q <= depth_q + DEPTH_W'(1);
            state_q <= CAL_ARM;
          end
        end
        default: ;
      endcase
    end
  end

  assign depth_o = depth_q;
  assign done_o  = (state_q == CAL_LOCK);
  assign fail_o  = (state_q == CAL_FAIL);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cal_start_i) |=> (done_o && $stable(depth_o)));

  a_r6_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !cal_start_i) |=> (fail_o && $stable(depth_o)));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_start_i |=> (depth_o == $past(depth_o) || depth_o == $past(depth_o) + DEPTH_W'(1)));

  a_r4_lock_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !cal_start_i) |=> (!done_o || $past(cap_word_i == train_word_i)));

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_i |=> (depth_o == '0 && !done_o && !fail_o));

endmodule

// File: rtl/rdq_align.sv
module rdq_align #(
  parameter int WORD_W     = 32,
  parameter int MAX_DEPTH  = 16,
  parameter int OUT_STAGES = 2,
  localparam int DEPTH_W   = $clog2(MAX_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_pulse_i,
  input  logic               cal_start_i,
  input  logic [WORD_W-1:0]  cap_word_i,
  input  logic [WORD_W-1:0]  train_word_i,
  output logic               fifo_we_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               cal_done_o,
  output logic               cal_fail_o
);

  logic               en_rise_w;
  logic               pipe_empty_w;
  logic [DEPTH_W-1:0] depth_w;

  rdq_tapline #(
    .MAX_DEPTH (MAX_DEPTH),
    .OUT_STAGES(OUT_STAGES),
    .DEPTH_W   (DEPTH_W)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_i  (rd_pulse_i),
    .depth_i  (depth_w),
    .en_o     (fifo_we_o),
    .en_rise_o(en_rise_w),
    .empty_o  (pipe_empty_w)
  );

  rdq_cal_fsm #(
    .WORD_W   (WORD_W),
    .MAX_DEPTH(MAX_DEPTH),
    .DEPTH_W  (DEPTH_W)
  ) u_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_start_i (cal_start_i),
    .pulse_i     (rd_pulse_i),
    .pipe_empty_i(pipe_empty_w),
    .en_rise_i   (en_rise_w),
    .cap_word_i  (cap_word_i),
    .train_word_i(train_word_i),
    .depth_o     (depth_w),
    .done_o      (cal_done_o),
    .fail_o      (cal_fail_o)
  );

  assign depth_o = depth_w;

  // R1: nothing is enabled on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!fifo_we_o && !cal_done_o && !cal_fail_o));

endmodule

// File: tb/rdq_align_test.sv
module rdq_align_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int MAX_DEPTH  = 16;
  localparam int OUT_STAGES = 2;
  localparam int READ_SPAN  = 40;
  localparam logic [WORD_W-1:0] TRAIN = 32'h55AA_00FF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_pulse = 1'b0;
  logic              cal_start = 1'b0;
  logic [WORD_W-1:0] cap_word = '0;
  logic [WORD_W-1:0] train_word = TRAIN;
  logic              fifo_we;
  logic [3:0]        depth;
  logic              done;
  logic              fail;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdq_align #(.WORD_W(WORD_W), .MAX_DEPTH(MAX_DEPTH), .OUT_STAGES(OUT_STAGES)) uut (
    .clk(clk), .rst_n(rst_n), .rd_pulse_i(rd_pulse), .cal_start_i(cal_start),
    .cap_word_i(cap_word), .train_word_i(train_word), .fifo_we_o(fifo_we),
    .depth_o(depth), .cal_done_o(done), .cal_fail_o(fail)
  );

  function automatic logic [WORD_W-1:0] junk(int c);
    return TRAIN ^ (32'h0101_0101 + WORD_W'(c));
  endfunction

  // Steps after the sampling edge at which the enable is high: depth+OUT_STAGES
  function automatic logic we_expected(int c, int d, int w);
    return (c >= d + OUT_STAGES) && (c < d + OUT_STAGES + w);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One read: pulse of width w; training word shows up lt steps after edge 1.
  task automatic do_read(input int lt, input int w, input bit chk_we, input int d);
    int we_bad = 0;
    @(negedge clk);
    rd_pulse = 1'b1;
    for (int c = 0; c < READ_SPAN; c++) begin
      @(posedge clk);
      #1;
      if (chk_we && (fifo_we !== we_expected(c, d, w))) we_bad++;
      if (c + 1 >= w) rd_pulse = 1'b0;
      cap_word = (c == lt) ? TRAIN : junk(c);
    end
    if (chk_we) check("R2/R3 enable timing and width", we_bad, 0);
  endtask

  task automatic start_cal();
    @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    check("R7 restart done", int'(done), 0);
    check("R7 restart fail", int'(fail), 0);
    check("R7 restart depth", int'(depth), 0);
  endtask

  task automatic train_case(input int lt, input int w);
    int reads = 0;
    start_cal();
    while (!done && !fail && reads < 20) begin
      do_read(lt, w, 1'b0, 0);
      reads++;
    end
    if (lt >= OUT_STAGES && lt < OUT_STAGES + MAX_DEPTH) begin
      check("R4 locked", int'(done), 1);
      check("R4 depth", int'(depth), lt - OUT_STAGES);
      check("R4 trial count", reads, lt - OUT_STAGES + 1);
      do_read(-1, w, 1'b1, lt - OUT_STAGES);
      do_read(-1, 3 - w, 1'b1, lt - OUT_STAGES);
      check("R5 depth held", int'(depth), lt - OUT_STAGES);
      check("R5 done held", int'(done), 1);
      check("R6 no fail on lock", int'(fail), 0);
    end else begin
      check("R6 fail flag", int'(fail), 1);
      check("R6 done low", int'(done), 0);
      check("R6 depth parked", int'(depth), MAX_DEPTH - 1);
      check("R6 trial count", reads, MAX_DEPTH);
      do_read(lt, w, 1'b0, 0);
      check("R6 fail sticky", int'(fail), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 we in reset", int'(fifo_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 we", int'(fifo_we), 0);
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    check("R1 depth", int'(depth), 0);
    do_read(-1, 1, 1'b1, 0);
    for (int lt = OUT_STAGES; lt < OUT_STAGES + MAX_DEPTH; lt++)
      train_case(lt, (lt % 2) + 1);
    train_case(OUT_STAGES + MAX_DEPTH, 2);
    train_case(OUT_STAGES - 1, 1);
    train_case(OUT_STAGES + 5, 2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule